// File: doc/BRIEF.md
# Up-Counting Timer with Shadowed Reload

This block is a general-purpose up-counting timer. A programmable prescaler divides the clock, and each time the prescaler wraps the main counter advances by one. The main counter runs from zero up to an active reload limit, then returns to zero and raises an overflow. The prescale ratio and the reload limit are written by software into preload registers. They move into the active (shadow) registers only on an update event, so a running period is never cut short by a write in the middle of it.

An update event comes from a counter overflow or from a software update-generate strobe. An update-disable control bit blocks all update events. An update-source select bit lets a software update take place without setting the update interrupt flag. The flag is sticky and is cleared by writing 1 to it. It raises an interrupt request when the interrupt enable bit is set. Software reaches every register through a single-cycle write port.

Top module: `reload_timer`

## Requirements
- R1: With the counter enabled, `cnt_o` steps up by one per prescaler wrap from 0 to the active limit and then returns to 0. `ovf_o` is high for exactly the one cycle in which `cnt_o` first shows 0 after the wrap.
- R2: When updates are allowed, an overflow is an update event. `upd_o` pulses in the same cycle as `ovf_o`, and the update flag `uif_o` is set whatever the source-select bit holds.
- R3: While the update-disable bit (control register, address 0, bit 1) is 1, no update event occurs. `upd_o` stays 0, the flag is not set, and the active limit and prescale keep their values, although the counter still wraps. Updates resume after the bit returns to 0.
- R4: Writing 1 to bit 0 at address 1 (update-generate) clears the counter and the prescaler counter, so `cnt_o` reads 0 in the next cycle. When updates are allowed it is also an update event (`upd_o` pulses), and the prescale ratio that follows is that of the active prescale value.
- R5: When the update-source bit (control register, bit 2) is 1, a software update-generate still reloads the shadows and pulses `upd_o`, but leaves `uif_o` at 0. An overflow-driven update still sets the flag.
- R6: `uif_o` stays set until a write of 1 to bit 0 at address 2 clears it. If an update that sets the flag lands in the same cycle as the clear, the flag stays set.
- R7: The active prescale value and the active limit load from their preload registers (prescale at address 3, limit at address 4) only on an update event. A preload write alone does not change the running period.
- R8: The prescaler counts from 0 to the active prescale value P, so the main counter advances once every P+1 cycles.
- R9: When a preload write and an update event fall in the same cycle, the shadow register takes the value just written.
- R10: After reset every register is 0, `cnt_o` is 0 and all outputs are 0. While the counter-enable bit (control register, bit 0) is 0, `cnt_o` holds its value.
- R11: `irq_o` is 1 exactly when `uif_o` is 1 and the interrupt-enable bit (control register, bit 3) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 event, 2 status, 3 prescale preload, 4 limit preload) |
| wr_data | input | DATA_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| ovf_o | output | 1 | Overflow pulse |
| upd_o | output | 1 | Update-event pulse |
| uif_o | output | 1 | Sticky update interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench changes the limit preload in the middle of a period and checks that the old limit still ends that period. A design that loads the shadow at once would wrap early. Software updates and overflows are driven with update-disable set, to catch a design that still reloads the limit or raises `upd_o`. A software update with the source bit set must leave the flag clear, while the next overflow must still set it. An update-generate is issued in the middle of a prescaled count, to catch a prescaler counter that is not cleared and would tick too soon. Two corners are steered onto exact clock edges: a flag clear that lands on a flag-setting overflow, and a limit write that lands on the overflow that loads it. A design that lets the clear win, or loads the stale preload, reads back the wrong flag or the wrong wrap point.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL = 3'd0,
      A_EVT  = 3'd1,
      A_STAT = 3'd2,
      A_PSC  = 3'd3,
      A_ARR  = 3'd4
   } addr_e;

   // control register layout, bit 0 upward: enable, update-disable, source-select, irq enable
   typedef struct packed {
      logic ie;
      logic urs;
      logic udis;
      logic en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   output ctrl_t                  ctrl,
   output logic                   ug_stb,
   output logic                   clr_stb,
   output logic [PSC_W-1:0]       psc_src,
   output logic [CNT_W-1:0]       arr_src
);
   logic [PSC_W-1:0] psc_pre;
   logic [CNT_W-1:0] arr_pre;
   logic             hit_psc, hit_arr;

   assign hit_psc = wr_en && (wr_addr == A_PSC);
   assign hit_arr = wr_en && (wr_addr == A_ARR);
   assign ug_stb  = wr_en && (wr_addr == A_EVT)  && wr_data[0];
   assign clr_stb = wr_en && (wr_addr == A_STAT) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         psc_pre <= '0;
         arr_pre <= '0;
      end else begin
         if (wr_en && (wr_addr == A_CTRL)) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (hit_psc) psc_pre <= wr_data[PSC_W-1:0];
         if (hit_arr) arr_pre <= wr_data[CNT_W-1:0];
      end
   end

   // value a shadow takes on an update: a same-cycle write wins
   assign psc_src = hit_psc ? wr_data[PSC_W-1:0] : psc_pre;
   assign arr_src = hit_arr ? wr_data[CNT_W-1:0] : arr_pre;
endmodule

// File: rtl/tmr_presc.sv
`timescale 1ns/1ps
module tmr_presc #(
   parameter int PSC_W   = 16,
   parameter bit USE_PSC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ug,
   input  logic             upd,
   input  logic [PSC_W-1:0] psc_src,
   output logic             tick,
   output logic [PSC_W-1:0] psc_act
);
   generate
      if (USE_PSC) begin : g_psc
         logic [PSC_W-1:0] pcnt, pact;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pcnt <= '0;
               pact <= '0;
            end else begin
               if (upd) pact <= psc_src;
               if (ug)
                  pcnt <= '0;
               else if (en)
                  pcnt <= (pcnt == pact) ? '0 : pcnt + 1'b1;
            end
         end
         assign tick    = en && !ug && (pcnt == pact);
         assign psc_act = pact;
      end else begin : g_direct
         assign tick    = en && !ug;
         assign psc_act = '0;
      end
   endgenerate
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ug,
   input  logic             upd,
   input  logic [CNT_W-1:0] arr_src,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] arr_act,
   output logic             ovf
);
   assign ovf = tick && (cnt == arr_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         arr_act <= '0;
      end else begin
         if (upd) arr_act <= arr_src;
         if (ug)
            cnt <= '0;
         else if (tick)
            cnt <= ovf ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_flag.sv
`timescale 1ns/1ps
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic sw_upd,
   input  logic urs,
   input  logic clr,
   input  logic ie,
   output logic uif,
   output logic irq
);
   logic set_flag;
   assign set_flag = upd && !(sw_upd && urs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        uif <= 1'b0;
      else if (set_flag) uif <= 1'b1;
      else if (clr)      uif <= 1'b0;
   end

   assign irq = uif && ie;
endmodule

// File: rtl/reload_timer.sv
`timescale 1ns/1ps
module reload_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 16,
   parameter int PSC_W   = 16,
   parameter bit USE_PSC = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [CNT_W-1:0]       cnt_o,
   output logic                   ovf_o,
   output logic                   upd_o,
   output logic                   uif_o,
   output logic                   irq_o
);
   generate
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("reload_timer: DATA_W too narrow for control register");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("reload_timer: CNT_W must lie in 2..DATA_W");
      end
      if (PSC_W < 1 || PSC_W > DATA_W) begin : g_bad_psc
         $error("reload_timer: PSC_W must lie in 1..DATA_W");
      end
   endgenerate

   ctrl_t            ctrl;
   logic             ug_stb, clr_stb, tick, ovf, upd_evt;
   logic [PSC_W-1:0] psc_src, psc_act;
   logic [CNT_W-1:0] arr_src, arr_act;

   tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl(ctrl), .ug_stb(ug_stb), .clr_stb(clr_stb),
      .psc_src(psc_src), .arr_src(arr_src)
   );

   assign upd_evt = !ctrl.udis && (ug_stb || ovf);

   tmr_presc #(.PSC_W(PSC_W), .USE_PSC(USE_PSC)) u_presc (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .ug(ug_stb), .upd(upd_evt),
      .psc_src(psc_src), .tick(tick), .psc_act(psc_act)
   );

   tmr_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ug(ug_stb), .upd(upd_evt),
      .arr_src(arr_src), .cnt(cnt_o), .arr_act(arr_act), .ovf(ovf)
   );

   tmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .upd(upd_evt), .sw_upd(ug_stb), .urs(ctrl.urs),
      .clr(clr_stb), .ie(ctrl.ie), .uif(uif_o), .irq(irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_o <= 1'b0;
         upd_o <= 1'b0;
      end else begin
         ovf_o <= ovf;
         upd_o <= upd_evt;
      end
   end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [CNT_W-1:0]  cnt_o,
   input logic              ovf_o,
   input logic              upd_o,
   input logic              uif_o,
   input logic              udis,
   input logic              urs,
   input logic [CNT_W-1:0]  arr_act,
   input logic [PSC_W-1:0]  psc_act
);
   logic sw_ug, sw_clr;
   assign sw_ug  = wr_en && (wr_addr == 3'd1) && wr_data[0];
   assign sw_clr = wr_en && (wr_addr == 3'd2) && wr_data[0];

   AST_WRAP_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) ovf_o |-> (cnt_o == '0)); // R1
   AST_STEP_ONE:     assert property (@(posedge clk) disable iff (!rst_n)
                        (cnt_o != $past(cnt_o)) |-> (cnt_o == '0 || cnt_o == $past(cnt_o) + 1'b1)); // R1
   AST_UG_CLEARS:    assert property (@(posedge clk) disable iff (!rst_n) sw_ug |=> (cnt_o == '0)); // R4
   AST_UDIS_BLOCKS:  assert property (@(posedge clk) disable iff (!rst_n) udis |=> !upd_o); // R3
   AST_URS_QUIET:    assert property (@(posedge clk) disable iff (!rst_n)
                        (sw_ug && urs && !uif_o) |=> !uif_o); // R5
   AST_FLAG_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
                        (uif_o && !sw_clr) |=> uif_o); // R6
   AST_FLAG_SOURCE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(uif_o) |-> upd_o); // R6
   AST_ARR_ON_UPD:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(arr_act) |-> upd_o); // R7
   AST_PSC_ON_UPD:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(psc_act) |-> upd_o); // R7
endmodule

bind reload_timer tmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .cnt_o(cnt_o), .ovf_o(ovf_o), .upd_o(upd_o), .uif_o(uif_o),
   .udis(ctrl.udis), .urs(ctrl.urs), .arr_act(arr_act), .psc_act(psc_act)
);

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] cnt_o;
   logic        ovf_o, upd_o, uif_o, irq_o;
   int          n_chk = 0;
   int          n_err = 0;

   always #2.5 clk = ~clk;

   reload_timer u_reload_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_o(cnt_o), .ovf_o(ovf_o), .upd_o(upd_o), .uif_o(uif_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called just after a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic ctl(input bit en, input bit udis, input bit urs, input bit ie);
      wr(3'd0, {12'd0, ie, urs, udis, en});
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input int psc, input int arr);
      ctl(0, 0, 0, 0);
      wr(3'd3, 16'(psc));
      wr(3'd4, 16'(arr));
      wr(3'd1, 16'd1);
      wr(3'd2, 16'd1);
   endtask

   task automatic t_reset();
      check("R10", "cnt after reset", cnt_o, 0);
      check("R10", "flag after reset", uif_o, 0);
      check("R10", "irq after reset", irq_o, 0);
      check("R10", "ovf/upd after reset", {ovf_o, upd_o}, 0);
      idle(4);
      check("R10", "cnt idle while disabled", cnt_o, 0);
   endtask

   task automatic t_count_and_defer();
      wr(3'd4, 16'd3);
      idle(2);
      check("R7", "cnt before any update", cnt_o, 0);
      wr(3'd1, 16'd1);
      check("R4", "upd_o on software update", upd_o, 1);
      check("R6", "flag set by software update", uif_o, 1);
      wr(3'd2, 16'd1);
      check("R6", "flag cleared by write", uif_o, 0);
      ctl(1, 0, 0, 0);
      idle(3);
      check("R1", "cnt at limit", cnt_o, 3);
      check("R1", "no ovf before wrap", ovf_o, 0);
      idle(1);
      check("R1", "cnt wraps to 0", cnt_o, 0);
      check("R1", "ovf pulse at wrap", ovf_o, 1);
      check("R2", "upd pulse at overflow", upd_o, 1);
      check("R2", "flag set at overflow", uif_o, 1);
      idle(1);
      check("R1", "ovf lasts one cycle", ovf_o, 0);
      ctl(0, 0, 0, 0);
      check("R10", "cnt at disable", cnt_o, 2);
      idle(4);
      check("R10", "cnt holds while disabled", cnt_o, 2);
      wr(3'd4, 16'd6);
      ctl(1, 0, 0, 0);
      idle(1);
      check("R7", "old limit still counted", cnt_o, 3);
      idle(1);
      check("R7", "old limit ends the period", cnt_o, 0);
      idle(6);
      check("R7", "new limit reached", cnt_o, 6);
      idle(1);
      check("R7", "wrap at new limit", cnt_o, 0);
   endtask

   task automatic t_prescale();
      restart(2, 5);
      ctl(1, 0, 0, 0);
      idle(2);
      check("R8", "no step before ratio", cnt_o, 0);
      idle(1);
      check("R8", "step after 3 cycles", cnt_o, 1);
      idle(3);
      check("R8", "second step", cnt_o, 2);
      idle(1);
      wr(3'd1, 16'd1);
      check("R4", "update-generate clears cnt", cnt_o, 0);
      idle(2);
      check("R4", "prescaler restarted", cnt_o, 0);
      idle(1);
      check("R4", "ratio kept after clear", cnt_o, 1);
   endtask

   task automatic t_update_disable();
      restart(0, 3);
      wr(3'd4, 16'd1);
      ctl(1, 1, 0, 0);
      idle(3);
      check("R3", "cnt at old limit", cnt_o, 3);
      idle(1);
      check("R3", "wrap still occurs", ovf_o, 1);
      check("R3", "no upd while disabled", upd_o, 0);
      check("R3", "no flag while disabled", uif_o, 0);
      idle(3);
      check("R3", "limit not reloaded", cnt_o, 3);
      wr(3'd1, 16'd1);
      check("R3", "sw update suppressed", upd_o, 0);
      check("R4", "cnt cleared under disable", cnt_o, 0);
      idle(3);
      check("R3", "limit still old after sw update", cnt_o, 3);
      ctl(1, 0, 0, 0);
      check("R3", "wrap on re-enable edge not an update", upd_o, 0);
      idle(3);
      check("R3", "counting continues", cnt_o, 3);
      idle(1);
      check("R3", "updates resume", upd_o, 1);
      check("R3", "flag resumes", uif_o, 1);
      idle(1);
      check("R3", "new limit 1 active", cnt_o, 1);
      idle(1);
      check("R3", "wrap at new limit", ovf_o, 1);
   endtask

   task automatic t_source_and_irq();
      restart(0, 2);
      ctl(0, 0, 1, 1);
      wr(3'd1, 16'd1);
      check("R5", "sw update still pulses upd", upd_o, 1);
      check("R5", "sw update leaves flag clear", uif_o, 0);
      check("R11", "no irq without flag", irq_o, 0);
      ctl(1, 0, 1, 1);
      idle(2);
      check("R1", "cnt at 2", cnt_o, 2);
      idle(1);
      check("R5", "overflow sets flag despite source bit", uif_o, 1);
      check("R11", "irq with flag and enable", irq_o, 1);
      wr(3'd2, 16'd1);
      check("R11", "irq drops with flag", irq_o, 0);
      ctl(1, 0, 1, 0);
      idle(1);
      check("R11", "flag set again", uif_o, 1);
      check("R11", "irq masked by enable", irq_o, 0);
      // cnt is 0 here; steer a clear onto the wrap edge
      wr(3'd2, 16'd1);
      check("R6", "clear works off the wrap", uif_o, 0);
      idle(1);
      wr(3'd2, 16'd1);
      check("R6", "set wins over same-cycle clear", uif_o, 1);
   endtask

   task automatic t_same_cycle();
      restart(0, 4);
      ctl(1, 0, 0, 0);
      idle(3);
      ctl(0, 0, 0, 0);
      check("R10", "held at limit", cnt_o, 4);
      ctl(1, 0, 0, 0);
      check("R10", "still at limit", cnt_o, 4);
      wr(3'd4, 16'd7);
      check("R9", "wrap on write edge", cnt_o, 0);
      check("R9", "update on write edge", upd_o, 1);
      idle(5);
      check("R9", "passes old limit", cnt_o, 5);
      idle(2);
      check("R9", "reaches written limit", cnt_o, 7);
      idle(1);
      check("R9", "wraps at written limit", cnt_o, 0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_count_and_defer();
      t_prescale();
      t_update_disable();
      t_source_and_irq();
      t_same_cycle();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #1000000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule